// File: doc/BRIEF.md
# Width-Selectable Level-Check FIFO

A synchronous first-in first-out buffer for the transmit or receive path of a serial controller. It holds 256 bytes of storage. A two-bit width code selects how that storage is carved into entries: single bytes, 16-bit halfwords or 32-bit words. This gives 256, 128 or 64 entries. The width is captured only when a clear operation runs. A width change therefore has no effect until the FIFO is cleared.

Traffic moves through a push/pop handshake. The head entry is always visible on the read data output, zero-extended to 32 bits. Software-facing logic outside this block reads the level, full and empty outputs. It also reads four registered level comparisons: a stop check, a low check, a high check and an 8-bit threshold-reached flag. The enclosing controller typically programs opposite check settings on its transmit and receive instances. A clear input empties the buffer. A run input gates every push and pop.

Top module: `level_fifo`

## Requirements
- R1: After reset or a cycle with `clr` high, the FIFO is empty, `level` is 0 and the width code present during that cycle becomes the active width.
- R2: The active width code gives the entry size and the capacity. Code 0 selects 8-bit entries (256 entries), code 1 selects 16-bit entries (128 entries), and codes 2 and 3 select 32-bit entries (64 entries). Changing `width_code` without a clear leaves the active width unchanged.
- R3: Entries leave in the order they arrived. `rd_data` shows the head entry: the low bits of the pushed data, zero-extended to 32 bits.
- R4: `level` is the entry count modulo 256, so a full byte-mode FIFO reads 0. `full` is high when the count equals the capacity, and `empty` is high when the count is zero.
- R5: A push while full, or a pop while empty, changes nothing. In the cycle after that clock edge, `push_err` or `pop_err` is high for one cycle per rejected request.
- R6: While `run` is low, pushes and pops are ignored and raise no error.
- R7: A push and a pop in the same cycle on a non-empty, non-full FIFO leave the count unchanged and advance the head.
- R8: `stop_hit` means count >= `stop_lim`, `high_hit` means count >= `high_lim`, and `low_hit` means count <= `low_lim`. These flags update on the same edge as `level`.
- R9: `thr_hit` means count >= `thr`, where `thr` is 8 bits. It updates on the same edge as `level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clear operation; empties the FIFO and captures the width |
| run | input | 1 | Enables pushes and pops |
| width_code | input | 2 | Entry size select |
| thr | input | 8 | Threshold for `thr_hit` |
| stop_lim | input | 6 | Stop-check limit |
| low_lim | input | 6 | Low-check limit |
| high_lim | input | 6 | High-check limit |
| push | input | 1 | Push request |
| wr_data | input | 32 | Data to push (low bits used) |
| pop | input | 1 | Pop request |
| rd_data | output | 32 | Head entry, zero-extended |
| level | output | 8 | Entry count modulo 256 |
| full | output | 1 | Count equals capacity |
| empty | output | 1 | Count is zero |
| thr_hit | output | 1 | Count at or above `thr` |
| stop_hit | output | 1 | Count at or above `stop_lim` |
| low_hit | output | 1 | Count at or below `low_lim` |
| high_hit | output | 1 | Count at or above `high_lim` |
| push_err | output | 1 | Rejected push pulse |
| pop_err | output | 1 | Rejected pop pulse |

## Verification
The properties assume that `run`, `clr`, `push` and `pop` are driven to known values on every clock edge after reset. They also assume that `width_code` matters only at a clear. The bench drives all inputs on the falling edge and zeroes the requests right after each rising edge. It changes `width_code` only while `run` is low, then applies an explicit clear whenever a new width must take effect. Only one deliberate case skips that clear, to show the old width stays active.

// File: rtl/level_fifo.sv
module level_fifo #(
  parameter int DEPTH_BYTES = 256,
  parameter int LW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [1:0]    width_code,
  input  logic [LW-1:0] thr,
  input  logic [CW-1:0] stop_lim,
  input  logic [CW-1:0] low_lim,
  input  logic [CW-1:0] high_lim,
  input  logic          push,
  input  logic [31:0]   wr_data,
  input  logic          pop,
  output logic [31:0]   rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          thr_hit,
  output logic          stop_hit,
  output logic          low_hit,
  output logic          high_hit,
  output logic          push_err,
  output logic          pop_err
);
  localparam int AW = $clog2(DEPTH_BYTES);
  localparam int NW = AW + 1;

  logic [7:0]    mem [DEPTH_BYTES];
  logic [1:0]    wsh;
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] cnt, cnt_n;
  logic [31:0]   raw;

  wire [NW-1:0] cap  = NW'(DEPTH_BYTES) >> wsh;
  wire [2:0]    step = 3'(1) << wsh;
  wire push_ok = run & push & ~full & ~clr;
  wire pop_ok  = run & pop & ~empty & ~clr;

  assign full  = (cnt == cap);
  assign empty = (cnt == '0);
  assign level = cnt[LW-1:0];
  assign cnt_n = clr ? '0 : cnt + NW'(push_ok) - NW'(pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsh <= 2'd2;
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      cnt <= cnt_n;
      if (clr) begin
        wsh <= (width_code == 2'd3) ? 2'd2 : width_code;
        wp  <= '0;
        rp  <= '0;
      end else begin
        if (push_ok) wp <= wp + AW'(step);
        if (pop_ok)  rp <= rp + AW'(step);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (push_ok && k < int'(step)) mem[wp + AW'(k)] <= wr_data[8*k +: 8];
  end

  always_comb begin
    raw = {mem[rp + AW'(3)], mem[rp + AW'(2)], mem[rp + AW'(1)], mem[rp]};
    case (wsh)
      2'd0:    rd_data = {24'd0, raw[7:0]};
      2'd1:    rd_data = {16'd0, raw[15:0]};
      default: rd_data = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hit  <= 1'b0;
      stop_hit <= 1'b0;
      low_hit  <= 1'b0;
      high_hit <= 1'b0;
      push_err <= 1'b0;
      pop_err  <= 1'b0;
    end else begin
      thr_hit  <= cnt_n >= NW'(thr);
      stop_hit <= cnt_n >= NW'(stop_lim);
      low_hit  <= cnt_n <= NW'(low_lim);
      high_hit <= cnt_n >= NW'(high_lim);
      push_err <= run & push & full & ~clr;
      pop_err  <= run & pop & empty & ~clr;
    end
  end
endmodule

// File: rtl/level_fifo_chk.sv
module level_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       run,
  input logic       push,
  input logic       pop,
  input logic [7:0] level,
  input logic       full,
  input logic       empty,
  input logic       push_err,
  input logic       pop_err
);
  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && level == 8'd0));
  // R4
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);
  // R4
  empty_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (level == 8'd0));
  // R5
  push_full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && push && full && !clr) |=> (push_err && $stable(level)));
  // R5
  pop_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pop && empty && !clr) |=> pop_err);
  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(level) && !push_err && !pop_err));
endmodule

bind level_fifo level_fifo_chk chk_i (.*);

// File: tb/level_fifo_tb_top.sv
module level_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, run = 1'b0;
  logic [1:0] width_code = 2'd1;
  logic [7:0] thr = 8'd200;
  logic [5:0] stop_lim = 6'd62, low_lim = 6'd32, high_lim = 6'd2;
  logic push = 1'b0, pop = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0] level;
  logic full, empty, thr_hit, stop_hit, low_hit, high_hit, push_err, pop_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  level_fifo dut_i (.*);

  // push, pop, data, expected level, expected head (16-bit mode)
  localparam logic [57:0] VEC [8] = '{
    {1'b1, 1'b0, 32'h1111_A001, 8'd1, 16'hA001},
    {1'b1, 1'b0, 32'h2222_B002, 8'd2, 16'hA001},
    {1'b1, 1'b0, 32'h0000_C003, 8'd3, 16'hA001},
    {1'b0, 1'b1, 32'h0,         8'd2, 16'hB002},
    {1'b1, 1'b1, 32'h5555_D004, 8'd2, 16'hC003},
    {1'b0, 1'b1, 32'h0,         8'd1, 16'hD004},
    {1'b0, 1'b1, 32'h0,         8'd0, 16'h0000},
    {1'b0, 1'b1, 32'h0,         8'd0, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit p, input bit q, input logic [31:0] d);
    @(negedge clk);
    push = p; pop = q; wr_data = d;
    @(posedge clk); #1;
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_clear(input logic [1:0] w);
    @(negedge clk);
    run = 1'b0; width_code = w; clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0; run = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(empty && !full && level == 0 && !push_err && !pop_err, "R1 reset state", {full, empty, level}, 32'h100);
    do_clear(2'd1);

    for (int i = 0; i < 8; i++) begin
      logic [57:0] v;
      v = VEC[i];
      cyc(v[57], v[56], v[55:24]);
      chk(level == v[23:16], "R7 R4 vector level", level, v[23:16]);
      if (v[23:16] != 0) chk(rd_data == {16'd0, v[15:0]}, "R3 vector head", rd_data, {16'd0, v[15:0]});
    end
    chk(pop_err, "R5 pop on empty flagged", pop_err, 1);
    cyc(0, 0, 0);
    chk(!pop_err, "R5 error is one cycle", pop_err, 0);

    do_clear(2'd2);
    thr = 8'd48;
    cyc(1, 0, 32'hC0DE_0000);
    chk(!high_hit && low_hit && !stop_hit && !thr_hit, "R8 R9 flags at count 1",
        {thr_hit, stop_hit, low_hit, high_hit}, 32'h2);
    cyc(1, 0, 32'hC0DE_0001);
    chk(high_hit, "R8 high at count 2", high_hit, 1);
    for (int k = 2; k < 64; k++) cyc(1, 0, 32'hC0DE_0000 + k);
    chk(full && level == 64, "R2 word mode holds 64", {full, level}, {1'b1, 8'd64});
    chk(stop_hit && high_hit && !low_hit && thr_hit, "R8 R9 flags when full",
        {thr_hit, stop_hit, low_hit, high_hit}, 32'hD);
    cyc(1, 0, 32'hDEAD_BEEF);
    chk(push_err && level == 64, "R5 push on full rejected", {push_err, level}, {1'b1, 8'd64});
    chk(rd_data == 32'hC0DE_0000, "R3 head unchanged after rejected push", rd_data, 32'hC0DE_0000);

    @(negedge clk) run = 1'b0;
    cyc(0, 1, 0);
    chk(level == 64 && !pop_err, "R6 pop ignored while stopped", {pop_err, level}, 32'd64);
    @(negedge clk) begin width_code = 2'd0; run = 1'b1; end
    cyc(0, 1, 0);
    chk(level == 63 && rd_data == 32'hC0DE_0001, "R2 width held without clear", rd_data, 32'hC0DE_0001);

    do_clear(2'd0);
    chk(empty && level == 0, "R1 clear empties", {empty, level}, 32'h100);
    for (int k = 0; k < 256; k++) cyc(1, 0, {24'hABCDEF, 8'(k) ^ 8'h5A});
    chk(full && !empty && level == 0, "R2 R4 byte mode 256 entries", {full, empty, level}, 32'h200);
    chk(rd_data == 32'h0000_005A, "R3 byte zero-extended", rd_data, 32'h5A);
    cyc(0, 1, 0);
    chk(rd_data == 32'h0000_005B && level == 8'd255, "R3 byte order", rd_data, 32'h5B);

    finish_run();
  end
endmodule